// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. It accepts 32-bit trace words over a valid/ready handshake and writes them into an internal RAM that it treats as a ring. Capture is started and stopped through a small word-addressed register port. Once capture has stopped, software reads the stored words back one at a time, oldest first.

Capture can end in several ways. Software can clear the enable bit. A trigger can be followed by a programmed number of further words. A flush can complete with the stop-on-flush option set. The flush is requested by software, or raised by the trigger. Status flags report whether the ring has wrapped, whether a trigger was seen, and whether the block is idle with its flush path empty.

Top module: `trace_ring_sink`

## Requirements
- R1: Registers sit at these word addresses (byte offset divided by four): depth 0x001, status 0x003, read data 0x004, read pointer 0x005, write pointer 0x006, post-trigger count 0x007, control 0x008, mode 0x00A, flush control 0x0C1. The depth register reads DEPTH, counted in 32-bit words. Depth, status, read data and both pointers are read-only. After reset the control register reads 0.
- R2: Writing 1 to control bit 0 starts capture. It clears the write pointer, the read pointer, the wrap and trigger flags and any unread data. Writing 0 to that bit stops capture.
- R3: traceReady is high only while capture runs. A word offered while traceReady is low is dropped, and the write pointer does not move.
- R4: Each accepted word is stored at the write pointer, which then advances by one and wraps from DEPTH-1 to 0. Status bit 0 is set when a word is stored in slot DEPTH-1.
- R5: With flush-control bit 8 set, a high trigIn during capture is the trigger event and sets status bit 1. With bit 8 clear, trigIn has no effect.
- R6: After the trigger event, exactly N more words are accepted, where N is the post-trigger count register, and then capture stops. If N is 0, capture stops at the clock edge that sees the trigger.
- R7: Writing 1 to flush-control bit 6 starts a flush. The bit reads 1 for FLUSH_CYCLES cycles and then clears itself. If bit 12 is set, capture stops when the flush completes; if bit 12 is clear, capture continues.
- R8: With flush-control bit 5 set, the trigger event also starts a flush. That flush behaves as in R7.
- R9: Status bit 2 (ready) is 1 exactly when capture is not running and no flush is in progress.
- R10: When capture stops, the read pointer is set to the write pointer if the ring has wrapped, and to 0 otherwise. Each read of the read-data register returns the next stored word, oldest first, and advances the read pointer with wrap at DEPTH.
- R11: The read-data register returns 0xFFFFFFFF once all stored words have been read, before any capture, and while capture runs.
- R12: The mode register holds 2 bits. Value 0 selects ring capture. Values 1 and 2 select the FIFO modes, in which no word is stored and traceReady stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 10 | Register word address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; a read of read data consumes a word |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| traceData | input | 32 | Incoming trace word |
| traceValid | input | 1 | traceData is valid |
| traceReady | output | 1 | Block takes the word at this edge |
| trigIn | input | 1 | External trigger |

## Verification
A wrong pointer or a wrong wrap flag does not show during capture. It shows at the first drain after capture stops, as words that are missing, repeated or out of order at the read-data register, or as 0xFFFFFFFF arriving too early or too late. A wrong trigger count, stop decision or flush timer shows within one cycle as traceReady staying high or dropping at the wrong word, and as the status and flush-control bits reading wrong values. The scoreboard therefore tracks every word the handshake accepts and checks the exact word at which capture ends.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  localparam int WORD_W     = 32;
  localparam int REG_ADDR_W = 10;

  localparam logic [REG_ADDR_W-1:0] ADDR_DEPTH   = 10'h001;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS  = 10'h003;
  localparam logic [REG_ADDR_W-1:0] ADDR_RDDATA  = 10'h004;
  localparam logic [REG_ADDR_W-1:0] ADDR_RDPTR   = 10'h005;
  localparam logic [REG_ADDR_W-1:0] ADDR_WRPTR   = 10'h006;
  localparam logic [REG_ADDR_W-1:0] ADDR_TRIGCNT = 10'h007;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL    = 10'h008;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE    = 10'h00A;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLUSH   = 10'h0C1;

  // flush-control bit positions
  localparam int FL_TRIG_FLUSH = 5;
  localparam int FL_MANUAL     = 6;
  localparam int FL_EXT_TRIG   = 8;
  localparam int FL_STOP       = 12;

  typedef enum logic [1:0] {
    MODE_RING    = 2'd0,
    MODE_SW_FIFO = 2'd1,
    MODE_HW_FIFO = 2'd2
  } cap_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // clear pointers and flags
    logic accept;  // store traceData this cycle
    logic snap;    // capture stops this cycle: load readout state
    logic pop;     // read-data register consumed
  } dp_strobe_t;
endpackage

// File: rtl/trace_ring_dp.sv
module trace_ring_dp
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [WORD_W-1:0] inWord,
  output logic [AW-1:0]     wrPtr,
  output logic [AW-1:0]     rdPtr,
  output logic              wrapped,
  output logic              dataLeft,
  output logic [WORD_W-1:0] rdWord
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CW-1:0]     unread;
  logic [AW-1:0]     wrNext;
  logic              wrapNext;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.accept) mem[wrPtr] <= inWord;
  end

  // next write state, so a stop in the same cycle as the last word sees it
  always_comb begin
    wrNext   = wrPtr;
    wrapNext = wrapped;
    if (stb.accept) begin
      wrNext = bump(wrPtr);
      if (wrPtr == LAST) wrapNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wrapped <= 1'b0;
      unread  <= '0;
    end else if (stb.start) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wrapped <= 1'b0;
      unread  <= '0;
    end else begin
      wrPtr   <= wrNext;
      wrapped <= wrapNext;
      if (stb.snap) begin
        rdPtr  <= wrapNext ? wrNext : '0;
        unread <= wrapNext ? CW'(DEPTH) : CW'(wrNext);
      end else if (stb.pop) begin
        rdPtr  <= bump(rdPtr);
        unread <= unread - 1'b1;
      end
    end
  end

  assign dataLeft = (unread != '0);
  assign rdWord   = mem[rdPtr];
endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import trace_ring_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int FLUSH_CYCLES = 4,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FCW = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [WORD_W-1:0]     regWdata,
  output logic [WORD_W-1:0]     regRdata,
  input  logic                  traceValid,
  output logic                  traceReady,
  input  logic                  trigIn,
  input  logic [AW-1:0]         wrPtr,
  input  logic [AW-1:0]         rdPtr,
  input  logic                  wrapped,
  input  logic                  dataLeft,
  input  logic [WORD_W-1:0]     rdWord,
  output dp_strobe_t            stb,
  output logic                  running,
  output logic                  flushBusy
);
  logic              capEn;
  logic [1:0]        mode;
  logic [WORD_W-1:0] trigLimit;
  logic [WORD_W-1:0] postCnt;
  logic              triggered;
  logic              trigFlush, extTrig, stopFlush;
  logic [FCW-1:0]    flushCnt;

  logic wrCtrl, startReq, haltReq, accept, trigEvt, postDone, zeroPost;
  logic flushWr, flushStart, flushDone, stopNow, readyFlag;

  always_comb begin
    wrCtrl     = regWr && (regAddr == ADDR_CTRL);
    startReq   = wrCtrl && regWdata[0];
    haltReq    = wrCtrl && !regWdata[0];
    flushBusy  = (flushCnt != '0);
    traceReady = running && (mode == MODE_RING);
    accept     = traceValid && traceReady && !startReq;
    trigEvt    = running && extTrig && trigIn && !triggered;
    zeroPost   = trigEvt && (trigLimit == '0);
    postDone   = triggered && accept && (postCnt == WORD_W'(1));
    flushWr    = regWr && (regAddr == ADDR_FLUSH);
    flushStart = !flushBusy && ((flushWr && regWdata[FL_MANUAL]) || (trigEvt && trigFlush));
    flushDone  = (flushCnt == FCW'(1));
    stopNow    = running && (haltReq || postDone || zeroPost || (flushDone && stopFlush));
    readyFlag  = !running && !flushBusy;
  end

  assign stb.start  = startReq;
  assign stb.accept = accept;
  assign stb.snap   = stopNow && !startReq;
  assign stb.pop    = regRd && (regAddr == ADDR_RDDATA) && dataLeft;

  // capture state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEn     <= 1'b0;
      running   <= 1'b0;
      triggered <= 1'b0;
      postCnt   <= '0;
    end else if (startReq) begin
      capEn     <= 1'b1;
      running   <= 1'b1;
      triggered <= 1'b0;
      postCnt   <= '0;
    end else begin
      if (haltReq) capEn <= 1'b0;
      if (stopNow) running <= 1'b0;
      if (trigEvt) begin
        triggered <= 1'b1;
        postCnt   <= trigLimit;
      end else if (triggered && accept && (postCnt != '0)) begin
        postCnt <= postCnt - 1'b1;
      end
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_RING;
      trigLimit <= '0;
      trigFlush <= 1'b0;
      extTrig   <= 1'b0;
      stopFlush <= 1'b0;
    end else begin
      if (regWr && (regAddr == ADDR_MODE))    mode      <= regWdata[1:0];
      if (regWr && (regAddr == ADDR_TRIGCNT)) trigLimit <= regWdata;
      if (flushWr) begin
        trigFlush <= regWdata[FL_TRIG_FLUSH];
        extTrig   <= regWdata[FL_EXT_TRIG];
        stopFlush <= regWdata[FL_STOP];
      end
    end
  end

  // flush timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flushCnt <= '0;
    else if (flushStart) flushCnt <= FCW'(FLUSH_CYCLES);
    else if (flushBusy)  flushCnt <= flushCnt - 1'b1;
  end

  // register read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_DEPTH:   regRdata = WORD_W'(DEPTH);
      ADDR_STATUS:  regRdata = {29'd0, readyFlag, triggered, wrapped};
      ADDR_RDDATA:  regRdata = dataLeft ? rdWord : '1;
      ADDR_RDPTR:   regRdata = WORD_W'(rdPtr);
      ADDR_WRPTR:   regRdata = WORD_W'(wrPtr);
      ADDR_TRIGCNT: regRdata = trigLimit;
      ADDR_CTRL:    regRdata = {31'd0, capEn};
      ADDR_MODE:    regRdata = {30'd0, mode};
      ADDR_FLUSH: begin
        regRdata[FL_TRIG_FLUSH] = trigFlush;
        regRdata[FL_MANUAL]     = flushBusy;
        regRdata[FL_EXT_TRIG]   = extTrig;
        regRdata[FL_STOP]       = stopFlush;
      end
      default:      regRdata = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trace_ring_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int FLUSH_CYCLES = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [WORD_W-1:0]     regWdata,
  output logic [WORD_W-1:0]     regRdata,
  input  logic [WORD_W-1:0]     traceData,
  input  logic                  traceValid,
  output logic                  traceReady,
  input  logic                  trigIn
);
  dp_strobe_t        stb;
  logic [AW-1:0]     wrPtr, rdPtr;
  logic              wrapped, dataLeft, running, flushBusy;
  logic [WORD_W-1:0] rdWord;

  trace_ring_ctrl #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .traceValid(traceValid), .traceReady(traceReady), .trigIn(trigIn),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrapped(wrapped),
    .dataLeft(dataLeft), .rdWord(rdWord),
    .stb(stb), .running(running), .flushBusy(flushBusy)
  );

  trace_ring_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inWord(traceData),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrapped(wrapped),
    .dataLeft(dataLeft), .rdWord(rdWord)
  );
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  regWr,
  input logic                  regRd,
  input logic                  wdataBit0,
  input logic [WORD_W-1:0]     regRdata,
  input logic                  traceValid,
  input logic                  traceReady,
  input logic                  running,
  input logic [AW-1:0]         wrPtr,
  input logic [AW-1:0]         rdPtr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic startWr, rdHit, takes;
  assign startWr = regWr && (regAddr == ADDR_CTRL) && wdataBit0;
  assign rdHit   = regRd && (regAddr == ADDR_RDDATA);
  assign takes   = traceValid && traceReady;

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> running && (wrPtr == '0) && (rdPtr == '0));

  assert_wrptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !takes && !startWr |=> $stable(wrPtr));

  assert_wrptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    takes && !startWr |=> wrPtr == (($past(wrPtr) == LAST) ? '0 : $past(wrPtr) + 1'b1));

  assert_rdptr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !running && !rdHit && !startWr |=> $stable(rdPtr));

  assert_empty_while_running_R11: assert property (@(posedge clk) disable iff (!rstN)
    running && (regAddr == ADDR_RDDATA) |-> regRdata == '1);
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .wdataBit0(regWdata[0]), .regRdata(regRdata),
  .traceValid(traceValid), .traceReady(traceReady),
  .running(running), .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/test_trace_ring_sink.sv
module test_trace_ring_sink;
  import trace_ring_pkg::*;

  localparam int DEPTH = 16;
  localparam int FLUSH_CYCLES = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic [31:0] traceData = '0;
  logic        traceValid = 1'b0, traceReady, trigIn = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  logic [31:0] seed = 32'h1234_0000;

  always #4ns clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) i_trace_ring_sink (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .traceData(traceData),
    .traceValid(traceValid), .traceReady(traceReady), .trigIn(trigIn)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1ns d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic expectReg(string req, string what, logic [9:0] a, logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, what, v, exp);
  endtask

  // driver: offers one word, records it in the scoreboard when taken
  task automatic pushWord(string req, bit expTaken);
    logic acc;
    seed = seed * 32'd1103515245 + 32'd12345;
    @(negedge clk);
    traceData = seed; traceValid = 1'b1;
    #1ns acc = traceReady;
    @(negedge clk);
    traceValid = 1'b0;
    check(req, "word taken", {31'd0, acc}, {31'd0, expTaken});
    if (acc) begin
      expQ.push_back(seed);
      if (expQ.size() > DEPTH) void'(expQ.pop_front());
    end
  endtask

  // monitor: pops expected words and compares design output
  task automatic drainCheck(string req);
    logic [31:0] v;
    while (expQ.size() > 0) begin
      logic [31:0] e;
      e = expQ.pop_front();
      regRead(ADDR_RDDATA, v);
      check(req, "read data", v, e);
    end
    regRead(ADDR_RDDATA, v);
    check("R11", "exhausted read", v, 32'hFFFF_FFFF);
  endtask

  task automatic startCap();
    expQ.delete();
    regWrite(ADDR_CTRL, 32'd1);
  endtask

  task automatic pulseTrig();
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    expectReg("R9", "status after reset", ADDR_STATUS, 32'd4);
    expectReg("R1", "depth", ADDR_DEPTH, DEPTH);
    expectReg("R1", "control after reset", ADDR_CTRL, 32'd0);
    expectReg("R1", "write pointer after reset", ADDR_WRPTR, 32'd0);
    expectReg("R11", "read data before capture", ADDR_RDDATA, 32'hFFFF_FFFF);
    check("R3", "ready after reset", {31'd0, traceReady}, 32'd0);

    // short capture, no wrap
    startCap();
    for (int i = 0; i < 5; i++) pushWord("R3", 1'b1);
    expectReg("R4", "write pointer after 5", ADDR_WRPTR, 32'd5);
    regWrite(ADDR_CTRL, 32'd0);
    expectReg("R9", "status stopped no wrap", ADDR_STATUS, 32'd4);
    expectReg("R10", "read pointer no wrap", ADDR_RDPTR, 32'd0);
    drainCheck("R10");

    // wrapping capture
    startCap();
    for (int i = 0; i < 20; i++) pushWord("R3", 1'b1);
    regWrite(ADDR_CTRL, 32'd0);
    expectReg("R4", "status wrapped", ADDR_STATUS, 32'd5);
    expectReg("R4", "write pointer wrapped", ADDR_WRPTR, 32'd4);
    expectReg("R10", "read pointer wrapped", ADDR_RDPTR, 32'd4);
    drainCheck("R10");

    // stopped: input dropped
    pushWord("R3", 1'b0);
    expectReg("R3", "write pointer unchanged", ADDR_WRPTR, 32'd4);

    // FIFO mode holds capture off
    regWrite(ADDR_MODE, 32'd1);
    expectReg("R12", "mode readback", ADDR_MODE, 32'd1);
    startCap();
    pushWord("R12", 1'b0);
    expectReg("R2", "status after restart", ADDR_STATUS, 32'd0);
    regWrite(ADDR_CTRL, 32'd0);
    regWrite(ADDR_MODE, 32'd0);

    // trigger input ignored without bit 8
    regWrite(ADDR_FLUSH, 32'd0);
    startCap();
    pushWord("R3", 1'b1);
    pulseTrig();
    expectReg("R5", "status trigger ignored", ADDR_STATUS, 32'd0);
    pushWord("R5", 1'b1);
    regWrite(ADDR_CTRL, 32'd0);

    // post-trigger count of 3
    regWrite(ADDR_TRIGCNT, 32'd3);
    regWrite(ADDR_FLUSH, 32'h0000_0100);
    startCap();
    for (int i = 0; i < 4; i++) pushWord("R6", 1'b1);
    pulseTrig();
    expectReg("R5", "status triggered running", ADDR_STATUS, 32'd2);
    for (int i = 0; i < 3; i++) pushWord("R6", 1'b1);
    pushWord("R6", 1'b0);
    expectReg("R6", "status after post count", ADDR_STATUS, 32'd6);
    drainCheck("R6");

    // post-trigger count of 0
    regWrite(ADDR_TRIGCNT, 32'd0);
    startCap();
    pushWord("R6", 1'b1);
    pushWord("R6", 1'b1);
    pulseTrig();
    check("R6", "ready after zero count", {31'd0, traceReady}, 32'd0);
    expectReg("R6", "status zero count", ADDR_STATUS, 32'd6);
    pushWord("R6", 1'b0);
    drainCheck("R6");

    // manual flush with stop
    startCap();
    pushWord("R7", 1'b1);
    pushWord("R7", 1'b1);
    regWrite(ADDR_FLUSH, 32'h0000_1040);
    expectReg("R7", "flush busy", ADDR_FLUSH, 32'h0000_1040);
    expectReg("R7", "flush cleared", ADDR_FLUSH, 32'h0000_1000);
    expectReg("R7", "status after stop flush", ADDR_STATUS, 32'd4);
    check("R7", "ready after stop flush", {31'd0, traceReady}, 32'd0);
    drainCheck("R7");

    // manual flush without stop
    startCap();
    regWrite(ADDR_FLUSH, 32'h0000_0040);
    expectReg("R7", "flush busy no stop", ADDR_FLUSH, 32'h0000_0040);
    expectReg("R9", "status during flush", ADDR_STATUS, 32'd0);
    repeat (4) @(negedge clk);
    expectReg("R7", "flush cleared no stop", ADDR_FLUSH, 32'd0);
    pushWord("R7", 1'b1);
    regWrite(ADDR_CTRL, 32'd0);

    // flush on trigger
    regWrite(ADDR_TRIGCNT, 32'd100);
    regWrite(ADDR_FLUSH, 32'h0000_1120);
    startCap();
    for (int i = 0; i < 3; i++) pushWord("R8", 1'b1);
    pulseTrig();
    expectReg("R8", "flush from trigger", ADDR_FLUSH, 32'h0000_1160);
    repeat (4) @(negedge clk);
    expectReg("R8", "status after trigger flush", ADDR_STATUS, 32'd6);
    drainCheck("R8");

    // restart clears flags and unread data
    startCap();
    expectReg("R2", "status after restart", ADDR_STATUS, 32'd0);
    expectReg("R11", "read data while running", ADDR_RDDATA, 32'hFFFF_FFFF);
    expectReg("R2", "write pointer after restart", ADDR_WRPTR, 32'd0);
    expectReg("R2", "control enabled", ADDR_CTRL, 32'd1);
    regWrite(ADDR_CTRL, 32'd0);
    expectReg("R2", "control cleared", ADDR_CTRL, 32'd0);

    summary();
  end
endmodule